// File: doc/BRIEF.md
# Byte Check-Bit Single-Error Corrector

This block guards one data byte with a 4-bit check code. Each cycle it takes a received byte and the check code stored with it. It recomputes the code from the byte and XORs the two codes to form a mismatch vector. It then uses a fixed lookup to map that vector to the one data bit that must be wrong, and inverts that bit.

Results appear on registered outputs one cycle after the inputs. A new byte can be accepted every cycle with no stall. Two flags go with each result. One reports that a mismatch was seen. The other reports that the mismatch vector is not a correctable pattern; in that case the byte is forwarded untouched.

Top module: `hcb_corrector`

## Requirements
- R1: The recomputed code bit 3 is the XOR of data bits 0, 2 and 5. Code bit 2 covers data bits 0, 3 and 6. Code bit 1 covers data bits 1, 2, 3 and 7. Code bit 0 covers data bits 4, 5, 6 and 7.
- R2: When the supplied code equals the recomputed code, the byte is forwarded unchanged and both flags are low.
- R3: The mismatch vector is the supplied code XOR the recomputed code, written as bits [3:0]. Six vectors with exactly two bits set each name one data bit to invert: 1100 inverts bit 0, 1010 inverts bit 2, 1001 inverts bit 5, 0110 inverts bit 3, 0101 inverts bit 6, and 0011 inverts bit 7.
- R4: Mismatch vector 0010 inverts data bit 1, and vector 0001 inverts data bit 4.
- R5: Every other nonzero mismatch vector sets the uncorrectable flag and forwards the byte unmodified. These are 1000, 0100, and any vector with three or four bits set.
- R6: The error-detected flag is high exactly when the mismatch vector is nonzero. This includes the uncorrectable cases.
- R7: The outputs reflect the inputs sampled at the previous rising clock edge. Consecutive cycles give independent results with no stall.
- R8: A synchronous active-high reset clears the output byte and both flags on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_in | input | 8 | Received data byte |
| chk_in | input | 4 | Check code stored with the byte |
| byte_out | output | 8 | Corrected byte, registered |
| err_detected | output | 1 | Mismatch seen, registered |
| uncorrectable | output | 1 | Mismatch with no table entry, registered |

## Verification
The bench injects every single-bit data fault into several distinct bytes. A decoder with a wrong table entry would invert the wrong bit and leave two bits wrong. Code-only faults on check bits 3 and 2, and on bits 1 and 0, separate the single-bit table entries from the uncorrectable ones. A design that treated them alike would either change a good byte or forward a bad one without the flag. Three- and four-bit mismatches check that the byte is left unmodified and that both flags rise together. Back-to-back vectors and a reset taken in the middle of the stream expose any stale pipeline state or an off-by-one latency.

// File: rtl/hcb_pkg.sv
package hcb_pkg;
  localparam int DATA_W = 8;
  localparam int CODE_W = 4;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CODE_W-1:0] code_t;

  // Coverage of each check bit over the data byte; index = check bit.
  // Column j of this matrix is the mismatch signature of data bit j.
  localparam logic [CODE_W-1:0][DATA_W-1:0] COVER = {
    8'h25,   // chk 3: bits 0,2,5
    8'h49,   // chk 2: bits 0,3,6
    8'h8E,   // chk 1: bits 1,2,3,7
    8'hF0    // chk 0: bits 4,5,6,7
  };
endpackage

// File: rtl/hcb_encode.sv
module hcb_encode
  import hcb_pkg::*;
(
  input  data_t data,
  output code_t code
);
  for (genvar i = 0; i < CODE_W; i++) begin : g_chk
    assign code[i] = ^(data & COVER[i]);
  end
endmodule

// File: rtl/hcb_locate.sv
module hcb_locate
  import hcb_pkg::*;
(
  input  code_t mismatch,
  output data_t flip_mask,
  output logic  no_match
);
  for (genvar j = 0; j < DATA_W; j++) begin : g_bit
    code_t sig;
    for (genvar i = 0; i < CODE_W; i++) begin : g_col
      assign sig[i] = COVER[i][j];
    end
    assign flip_mask[j] = (mismatch == sig);
  end

  assign no_match = (mismatch != '0) && (flip_mask == '0);
endmodule

// File: rtl/hcb_corrector.sv
module hcb_corrector
  import hcb_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   byte_in,
  input  logic [CODE_W-1:0]   chk_in,
  output logic [DATA_W-1:0]   byte_out,
  output logic                err_detected,
  output logic                uncorrectable
);
  code_t recomputed;
  code_t mismatch;
  data_t flip_mask;
  logic  no_match;
  logic  live_q;

  hcb_encode u_enc (
    .data (byte_in),
    .code (recomputed)
  );

  assign mismatch = chk_in ^ recomputed;

  hcb_locate u_loc (
    .mismatch  (mismatch),
    .flip_mask (flip_mask),
    .no_match  (no_match)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_out      <= '0;
      err_detected  <= 1'b0;
      uncorrectable <= 1'b0;
      live_q        <= 1'b0;
    end else begin
      byte_out      <= byte_in ^ flip_mask;
      err_detected  <= (mismatch != '0);
      uncorrectable <= no_match;
      live_q        <= 1'b1;
    end
  end

  // R5 / R6: an uncorrectable result is always also a detected error
  a_r5_unc_flags: assert property (@(posedge clk) disable iff (rst)
    uncorrectable |-> err_detected);

  // R2: a clean result forwards the previous input byte
  a_r2_clean_pass: assert property (@(posedge clk) disable iff (rst)
    (live_q && !err_detected) |-> (byte_out == $past(byte_in)));

  // R3 / R4: a corrected result differs from the input in exactly one bit
  a_r3_one_flip: assert property (@(posedge clk) disable iff (rst)
    (live_q && err_detected && !uncorrectable)
      |-> ($countones(byte_out ^ $past(byte_in)) == 1));

  // R5: an uncorrectable result leaves the byte untouched
  a_r5_unmodified: assert property (@(posedge clk) disable iff (rst)
    (live_q && uncorrectable) |-> (byte_out == $past(byte_in)));

  // R3: the locator never selects more than one bit
  a_r3_onehot_mask: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flip_mask));

  // R8: the cycle after reset, the outputs are cleared
  a_r8_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (byte_out == '0 && !err_detected && !uncorrectable));
endmodule

// File: tb/hcb_corrector_test.sv
module hcb_corrector_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] byte_in = 8'h00;
  logic [3:0] chk_in  = 4'h0;
  logic [7:0] byte_out;
  logic       err_detected;
  logic       uncorrectable;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [7:0] b;
    logic       e;
    logic       u;
    string      req;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  hcb_corrector uut (
    .clk           (clk),
    .rst           (rst),
    .byte_in       (byte_in),
    .chk_in        (chk_in),
    .byte_out      (byte_out),
    .err_detected  (err_detected),
    .uncorrectable (uncorrectable)
  );

  // Independent model of R1
  function automatic logic [3:0] ref_code(input logic [7:0] d);
    ref_code[3] = d[0] ^ d[2] ^ d[5];
    ref_code[2] = d[0] ^ d[3] ^ d[6];
    ref_code[1] = d[1] ^ d[2] ^ d[3] ^ d[7];
    ref_code[0] = d[4] ^ d[5] ^ d[6] ^ d[7];
  endfunction

  // Drive one vector at the falling edge and queue its expected result
  task automatic apply(input logic [7:0] d, input logic [3:0] c, input string req);
    exp_t x;
    logic [3:0] mm;
    int pos;
    @(negedge clk);
    byte_in = d;
    chk_in  = c;
    mm  = c ^ ref_code(d);
    pos = -1;
    case (mm)
      4'b1100: pos = 0;
      4'b1010: pos = 2;
      4'b1001: pos = 5;
      4'b0110: pos = 3;
      4'b0101: pos = 6;
      4'b0011: pos = 7;
      4'b0010: pos = 1;
      4'b0001: pos = 4;
      default: pos = -1;
    endcase
    x.b   = (pos >= 0) ? (d ^ (8'h01 << pos)) : d;
    x.e   = (mm != 4'b0000);
    x.u   = (mm != 4'b0000) && (pos < 0);
    x.req = req;
    sb.push_back(x);
  endtask

  // Monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        vectors++;
        if (byte_out !== x.b || err_detected !== x.e || uncorrectable !== x.u) begin
          fails++;
          $display("FAIL %s: got byte=%h err=%b unc=%b exp byte=%h err=%b unc=%b",
                   x.req, byte_out, err_detected, uncorrectable, x.b, x.e, x.u);
        end
      end
    end
  end

  task automatic check_reset(input string req);
    @(posedge clk);
    #1;
    vectors++;
    if (byte_out !== 8'h00 || err_detected !== 1'b0 || uncorrectable !== 1'b0) begin
      fails++;
      $display("FAIL %s: got byte=%h err=%b unc=%b exp byte=00 err=0 unc=0",
               req, byte_out, err_detected, uncorrectable);
    end
  endtask

  initial begin
    logic [7:0] lfsr;
    byte_in = 8'hA5;
    chk_in  = 4'hF;
    check_reset("R8");
    check_reset("R8");
    @(negedge clk);
    rst = 1'b0;

    // R2 / R1 / R7: clean bytes back to back
    lfsr = 8'h1D;
    for (int k = 0; k < 24; k++) begin
      apply(lfsr, ref_code(lfsr), "R2");
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    apply(8'h00, 4'h0, "R1");
    apply(8'hFF, ref_code(8'hFF), "R1");

    // R3 / R4: every single data-bit fault on several bytes
    foreach (lfsr[i]) begin end
    for (int k = 0; k < 4; k++) begin
      logic [7:0] g;
      g = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h3C : 8'h96;
      for (int j = 0; j < 8; j++) begin
        apply(g ^ (8'h01 << j), ref_code(g), (j == 1 || j == 4) ? "R4" : "R3");
      end
    end

    // R4: lone mismatch on check bits 1 and 0 flips data bits 1 and 4
    apply(8'h5A, ref_code(8'h5A) ^ 4'b0010, "R4");
    apply(8'h5A, ref_code(8'h5A) ^ 4'b0001, "R4");

    // R5 / R6: patterns with no table entry
    apply(8'h5A, ref_code(8'h5A) ^ 4'b1000, "R5");
    apply(8'hC3, ref_code(8'hC3) ^ 4'b0100, "R5");
    apply(8'h71, ref_code(8'h71) ^ 4'b1110, "R5");
    apply(8'h71, ref_code(8'h71) ^ 4'b1101, "R5");
    apply(8'h0F, ref_code(8'h0F) ^ 4'b1011, "R5");
    apply(8'h0F, ref_code(8'h0F) ^ 4'b0111, "R6");
    apply(8'hE8, ref_code(8'hE8) ^ 4'b1111, "R6");

    // R7: alternating clean / faulty / uncorrectable, no gaps
    for (int k = 0; k < 16; k++) begin
      logic [7:0] d;
      d = 8'h11 * k[7:0];
      case (k % 3)
        0: apply(d, ref_code(d), "R7");
        1: apply(d ^ 8'h40, ref_code(d), "R7");
        default: apply(d, ref_code(d) ^ 4'b1000, "R7");
      endcase
    end

    // Drain, then reset mid-stream
    repeat (3) @(negedge clk);
    byte_in = 8'h3C;
    chk_in  = 4'h0;
    rst = 1'b1;
    check_reset("R8");
    @(negedge clk);
    rst = 1'b0;
    apply(8'h3C, ref_code(8'h3C) ^ 4'b0011, "R3");
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule